// File: doc/BRIEF.md
# Idle Auto-Halt Power Controller

This block sits beside a DRAM controller and decides when the memory devices may be parked in self-refresh. Once software launches it, it counts clock cycles in which the controller reports that it has nothing to do. When that run of idle cycles reaches a programmed threshold, it emits a one-cycle halt command. The command logic downstream then puts the devices into self-refresh.

While the devices are halted, software may raise the pad power-on level, and the block refuses that level at any other time. A wake request brings the devices back with a one-cycle unhalt command. The block holds the wake request back for as long as the pad power-on level is still high. The launch bit clears itself once the controller is running. The block does not generate the DRAM command timing and does not touch the address or data path.

Top module: `idle_halt_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `halt_cmd`, `unhalt_cmd`, `pad_pon` and `running` are all 0, and the block sits stopped.
- R2: A write with `cfg_sel`=0 and `cfg_wdata[0]`=1 while stopped launches the controller. The launch bit clears itself, and `running` goes high two cycles after the write cycle. The same write while running has no effect.
- R3: A write with `cfg_sel`=1 loads the idle threshold from `cfg_wdata[30:0]`. While running, the threshold-th consecutive clock edge with `idle_in` high ends the run, and `halt_cmd` is high in the cycle after that edge.
- R4: A clock edge with `idle_in` low resets the idle count to zero.
- R5: `halt_cmd` and `unhalt_cmd` are single-cycle pulses. No further halt is issued while halted, however long `idle_in` stays high.
- R6: `cfg_wdata[31]` of a `cfg_sel`=1 write sets `pad_pon`. A 1 is accepted only while halted, and outside that state `pad_pon` stays 0.
- R7: While halted, a wake request waits while `pad_pon` is 1. On the first edge that sees `wake_req` high and `pad_pon` low, the block leaves the halted state, and `unhalt_cmd` is high in the following cycle.
- R8: After an unhalt the controller runs again with its idle count restarted from zero.
- R9: A threshold of 0 disables automatic halting.
- R10: `wake_req` has no effect unless the block is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0: launch register, 1: threshold / pad power register |
| cfg_wdata | input | 32 | Write data |
| idle_in | input | 1 | Controller has no pending work this cycle |
| wake_req | input | 1 | Request to leave self-refresh |
| halt_cmd | output | 1 | One-cycle request to enter self-refresh |
| unhalt_cmd | output | 1 | One-cycle request to leave self-refresh |
| pad_pon | output | 1 | Pad power-on level |
| running | output | 1 | Controller has been launched |

## Verification
The bench builds the block with its default 31-bit threshold field and programs small thresholds of 1 and 5. These values let the exact cycle of every halt pulse be predicted and scored within a short run. The threshold of 1 exercises a halt on the very first idle edge, and a re-halt immediately after an unhalt. A threshold of 0 is held for a long idle stretch to show that automatic halting is disabled. The pad power-on interlock is driven both inside and outside the halted state, and together with a pending wake request.

// File: rtl/idle_halt_pkg.sv
// Shared types for the idle auto-halt controller.
// Assumes: nothing beyond a 3-bit state encoding.
package idle_halt_pkg;
    typedef enum logic [2:0] {
        ST_STOPPED,
        ST_RUNNING,
        ST_HALTING,
        ST_HALTED,
        ST_UNHALTING
    } pwr_state_e;
endpackage

// File: rtl/ihc_cfg_regs.sv
// Configuration storage: self-clearing launch bit, idle threshold, pad power level.
// Assumes: pon_allow_i is high only while a PON=1 write may legally land.
module ihc_cfg_regs #(
    parameter int LIMIT_W = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [LIMIT_W:0]   wr_data,
    input  logic               start_taken_i,
    input  logic               pon_allow_i,
    output logic               start_q,
    output logic [LIMIT_W-1:0] limit_q,
    output logic               pon_q
);
    // Launch bit: set by software, cleared when the sequencer consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= 1'b0;
        else if (start_taken_i)
            start_q <= 1'b0;
        else if (wr_en && !wr_sel && wr_data[0])
            start_q <= 1'b1;
    end

    // Threshold and pad power level: PON=1 only lands while permitted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
            pon_q   <= 1'b0;
        end else if (wr_en && wr_sel) begin
            limit_q <= wr_data[LIMIT_W-1:0];
            pon_q   <= wr_data[LIMIT_W] & pon_allow_i;
        end
    end

    // R2
    // start_clear_chk: a consumed launch bit is gone on the next cycle
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && start_taken_i) |=> !start_q);
endmodule

// File: rtl/ihc_idle_counter.sv
// Counts consecutive idle cycles and flags when the threshold is reached.
// Assumes: count_en is high only while the controller is running.
module ihc_idle_counter #(
    parameter int LIMIT_W = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               count_en,
    input  logic               idle_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               hit_o
);
    localparam int CW = LIMIT_W + 1;

    logic [LIMIT_W-1:0] cnt_q;
    logic [CW-1:0]      next_cnt;

    // Threshold compare; a lowered threshold still trips at once.
    always_comb begin
        next_cnt = {1'b0, cnt_q} + CW'(1);
        hit_o    = count_en && idle_i && (limit_i != '0) &&
                   (next_cnt >= {1'b0, limit_i});
    end

    // Count idle edges; cleared on activity, on hit, or when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !count_en || !idle_i || hit_o)
            cnt_q <= '0;
        else
            cnt_q <= next_cnt[LIMIT_W-1:0];
    end

    // R9
    // zero_limit_chk: a zero threshold never flags a hit
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_i == '0) |-> !hit_o);
endmodule

// File: rtl/ihc_halt_fsm.sv
// Power sequencer: stopped, running, halting, halted, unhalting.
// Assumes: hit_i is qualified by the running state upstream.
module ihc_halt_fsm
    import idle_halt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic hit_i,
    input  logic wake_i,
    input  logic pon_i,
    output logic halt_o,
    output logic unhalt_o,
    output logic run_o,
    output logic count_en_o,
    output logic start_taken_o,
    output logic pon_allow_o
);
    pwr_state_e state_q, state_d;
    logic       leave_halt;

    // Next-state selection.
    always_comb begin
        leave_halt = (state_q == ST_HALTED) && wake_i && !pon_i;
        state_d    = state_q;
        case (state_q)
            ST_STOPPED:   if (start_i) state_d = ST_RUNNING;
            ST_RUNNING:   if (hit_i)   state_d = ST_HALTING;
            ST_HALTING:   state_d = ST_HALTED;
            ST_HALTED:    if (leave_halt) state_d = ST_UNHALTING;
            ST_UNHALTING: state_d = ST_RUNNING;
            default:      state_d = ST_STOPPED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // Moore outputs decoded from the state.
    always_comb begin
        halt_o        = (state_q == ST_HALTING);
        unhalt_o      = (state_q == ST_UNHALTING);
        run_o         = (state_q != ST_STOPPED);
        count_en_o    = (state_q == ST_RUNNING);
        start_taken_o = (state_q == ST_STOPPED) && start_i;
        pon_allow_o   = (state_q == ST_HALTED) && !leave_halt;
    end

    // R6
    // pon_halted_chk: pad power is only up while halted
    pon_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pon_i |-> (state_q == ST_HALTED));

    // R7
    // unhalt_pon_low_chk: unhalt never issues with pad power up
    unhalt_pon_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unhalt_o |-> !pon_i);

    // R5
    // halt_pulse_chk: halt is one cycle wide
    halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> !halt_o);

    // R5
    // unhalt_pulse_chk: unhalt is one cycle wide
    unhalt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unhalt_o |=> !unhalt_o);

    // R3
    // hit_halts_chk: a threshold hit while running yields a halt next cycle
    hit_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en_o && hit_i) |=> halt_o);
endmodule

// File: rtl/idle_halt_ctrl.sv
// Top: idle auto-halt controller. Wires register file, idle counter, sequencer.
// Assumes: cfg_wdata[LIMIT_W] carries the pad power bit, lower bits the threshold.
module idle_halt_ctrl #(
    parameter int LIMIT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [LIMIT_W:0] cfg_wdata,
    input  logic             idle_in,
    input  logic             wake_req,
    output logic             halt_cmd,
    output logic             unhalt_cmd,
    output logic             pad_pon,
    output logic             running
);
    logic               start_q, start_taken, pon_allow, count_en, hit;
    logic [LIMIT_W-1:0] limit_q;

    ihc_cfg_regs #(.LIMIT_W(LIMIT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_sel(cfg_sel),
        .wr_data(cfg_wdata), .start_taken_i(start_taken),
        .pon_allow_i(pon_allow), .start_q(start_q), .limit_q(limit_q),
        .pon_q(pad_pon)
    );

    ihc_idle_counter #(.LIMIT_W(LIMIT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .idle_i(idle_in),
        .limit_i(limit_q), .hit_o(hit)
    );

    ihc_halt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_q), .hit_i(hit),
        .wake_i(wake_req), .pon_i(pad_pon), .halt_o(halt_cmd),
        .unhalt_o(unhalt_cmd), .run_o(running), .count_en_o(count_en),
        .start_taken_o(start_taken), .pon_allow_o(pon_allow)
    );

    // R1
    // reset_quiet_chk: no command during the cycle after reset
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !(halt_cmd || unhalt_cmd || pad_pon || running));

    // R10
    // wake_ignored_chk: wake outside halt never produces an unhalt
    wake_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && wake_req) |=> !unhalt_cmd);
endmodule

// File: tb/idle_halt_ctrl_test.sv
module idle_halt_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        idle_in = 1'b0;
    logic        wake_req = 1'b0;
    logic        halt_cmd, unhalt_cmd, pad_pon, running;

    int cyc = 0;
    int total = 0;
    int fails = 0;

    typedef struct { int kind; int at; string req; } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    idle_halt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .idle_in(idle_in), .wake_req(wake_req),
        .halt_cmd(halt_cmd), .unhalt_cmd(unhalt_cmd), .pad_pon(pad_pon),
        .running(running)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input int at, input string req);
        exp_t e;
        e.kind = kind; e.at = at; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: every command pulse must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && (halt_cmd || unhalt_cmd)) begin
            int kind;
            kind = halt_cmd ? 0 : 1;
            if (sb.size() == 0) begin
                check(1'b0, "R5/R10 unexpected pulse", kind, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.kind == kind, e.req, kind, e.kind);
                check(e.at == cyc, e.req, cyc, e.at);
            end
        end
    end

    task automatic write(input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Start an idle run from a clean count; the halt lands L edges later.
    task automatic go_idle(input int lim, input string req);
        @(negedge clk);
        idle_in = 1'b1;
        push(0, cyc + lim, req);
    endtask

    task automatic finish_run;
        check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check(!halt_cmd && !unhalt_cmd && !pad_pon && !running, "R1 in reset",
              {halt_cmd, unhalt_cmd, pad_pon, running}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!running && !pad_pon, "R1 after reset", {pad_pon, running}, 0);

        // R3: threshold 5 loaded while stopped; idle while stopped does nothing
        write(1'b1, 32'd5);
        idle_in = 1'b1;
        repeat (10) @(negedge clk);
        check(!running, "R2 idle while stopped stays stopped", running, 0);
        idle_in = 1'b0;

        // R2: launch, running two cycles after write cycle
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'd1; c = cyc;
        @(negedge clk);
        cfg_wr = 1'b0;
        check(!running, "R2 running not yet", running, 0);
        @(negedge clk);
        check(running && cyc == c + 2, "R2 running after launch", running, 1);

        // R6: PON=1 while running is refused
        write(1'b1, {1'b1, 31'd5});
        @(negedge clk);
        check(!pad_pon, "R6 pon refused while running", pad_pon, 0);

        // R10: wake while running is ignored
        @(negedge clk); wake_req = 1'b1;
        repeat (4) @(negedge clk);
        wake_req = 1'b0;
        check(running, "R10 still running after wake", running, 1);

        // R3: halt after 5 idle edges
        go_idle(5, "R3 halt at threshold");
        // R5: staying idle for long produces no second halt
        repeat (30) @(negedge clk);
        idle_in = 1'b0;

        // R6: PON=1 accepted while halted
        write(1'b1, {1'b1, 31'd5});
        check(pad_pon, "R6 pon accepted while halted", pad_pon, 1);

        // R7: wake held while PON high
        @(negedge clk); wake_req = 1'b1;
        repeat (6) @(negedge clk);
        check(pad_pon, "R7 pon still up, no unhalt", pad_pon, 1);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = {1'b0, 31'd5};
        push(1, cyc + 2, "R7 unhalt after pon drop");
        @(negedge clk);
        cfg_wr = 1'b0;
        check(!pad_pon, "R7 pon cleared", pad_pon, 0);
        repeat (2) @(negedge clk);
        wake_req = 1'b0;
        @(negedge clk);

        // R4: a busy edge in the middle of an idle run restarts the count
        idle_in = 1'b1;
        repeat (4) @(negedge clk);
        idle_in = 1'b0;
        go_idle(5, "R4 count restarted by busy edge");
        repeat (8) @(negedge clk);

        // R2: launch write while running has no effect
        write(1'b0, 32'd1);
        check(running, "R2 relaunch no effect", running, 1);

        // R8 + threshold 1: halt on first idle edge, re-halt right after unhalt
        write(1'b1, 32'd0);   // idle still high, halted already: harmless
        write(1'b1, 32'd1);
        idle_in = 1'b0;
        @(negedge clk);
        // still halted from previous run; wake with idle high
        idle_in = 1'b1;
        @(negedge clk);
        wake_req = 1'b1;
        push(1, cyc + 1, "R7 unhalt prompt");
        push(0, cyc + 3, "R8 count restarts after unhalt");
        @(negedge clk);
        wake_req = 1'b0;
        repeat (5) @(negedge clk);
        idle_in = 1'b0;

        // R9: threshold 0 disables halting
        write(1'b1, 32'd0);
        @(negedge clk);
        wake_req = 1'b1;
        push(1, cyc + 1, "R9 unhalt before disabled run");
        @(negedge clk);
        wake_req = 1'b0;
        idle_in = 1'b1;
        repeat (60) @(negedge clk);
        check(running && !pad_pon, "R9 no halt with zero threshold", running, 1);
        idle_in = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule